// File: doc/BRIEF.md
# Guest Interrupt Register Trap Decoder

This block decides, for every access that a guest kernel makes to an interrupt-controller system register, whether the access must be diverted to the hypervisor or may proceed. Each access arrives as a one-cycle strobe carrying a register class, a read/write flag, a physical/virtual variant flag and the privilege level of the requester. The hypervisor's control word supplies the trap enables. Exactly one cycle after each strobe the block raises either a trap pulse or a pass pulse.

Two related controls from the same word are also handled here. A trap enable for locally generated system-error interrupts turns each such event into a one-cycle trap pulse. A mask bit for directly injected virtual interrupts is passed on as a level to the pending-priority logic. Optional controls that the configuration leaves out are forced to zero, both in their effect and in the effective control word that the block reports.

Top module: `virq_trap_decoder`

## Requirements
- R1: While reset is asserted, and in the cycles that follow its release with no strobe and no error event, `trap_o`, `pass_o` and `sei_trap_o` are 0.
- R2: A guest-level access (`acc_lvl_i` = 1) of class 1 (group 1 registers), read or write, physical or virtual, traps when control bit 12 is 1.
- R3: A guest-level access of class 0 (group 0 registers) traps when control bit 11 is 1.
- R4: A guest-level access of class 2 (registers common to both groups) or class 3 (deactivate register) traps, in either direction, when control bit 10 is 1.
- R5: With control bit 14 set and `HAS_DEACT_TRAP` = 1, a guest-level write of class 3 traps when `acc_virt_i` = 1, and with `acc_virt_i` = 0 only when `PHYS_DEACT_TRAP` = 1; reads of class 3 are not trapped by bit 14, and with `HAS_DEACT_TRAP` = 0 bit 14 has no effect.
- R6: An access from any level other than 1 (`acc_lvl_i` = 0, 2 or 3) never traps and is passed.
- R7: One cycle after each strobe exactly one of `trap_o` and `pass_o` is 1 for exactly one cycle; with no strobe both stay 0; a guest access that no enable selects is passed.
- R8: When `sei_evt_i` is 1, `sei_trap_o` is 1 in the next cycle exactly when control bit 13 is 1 and `HAS_SEI` = 1.
- R9: `dimask_o` equals control bit 15 when `HAS_DIRECT_MASK` = 1 and is 0 otherwise, with no clock delay.
- R10: `ctl_eff_o` equals `ctl_i` with bits 13, 14 and 15 cleared when `HAS_SEI`, `HAS_DEACT_TRAP` and `HAS_DIRECT_MASK` respectively are 0; bits 0 to 9 have no effect on any trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_vld_i | input | 1 | One-cycle access strobe |
| acc_class_i | input | 2 | Register class: 0 group 0, 1 group 1, 2 common, 3 deactivate |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| acc_virt_i | input | 1 | 1 for the virtual register variant, 0 for the physical |
| acc_lvl_i | input | 2 | Privilege level of the requester (1 = guest kernel) |
| ctl_i | input | 16 | Hypervisor control word holding the trap enables |
| sei_evt_i | input | 1 | Locally generated system-error interrupt event |
| trap_o | output | 1 | One-cycle trap request, one cycle after the strobe |
| pass_o | output | 1 | One-cycle pass indication, one cycle after the strobe |
| sei_trap_o | output | 1 | One-cycle trap request for a system-error event |
| dimask_o | output | 1 | Mask for directly injected virtual interrupts |
| ctl_eff_o | output | 16 | Control word with unsupported optional bits read as zero |

## Verification
The bench sweeps every combination of the six trap-control bits against every class, direction, variant and level, on three configurations that differ in physical deactivate trapping and in which optional bits exist. It targets the deactivate class, where a design that ignored the variant flag or the write flag would trap physical writes or reads it must pass, and where a design that ignored the capability parameter would honour bit 14 when it should not. It also targets requesters at levels 0, 2 and 3, which a level-blind design would trap, and back-to-back strobes, where a stretched or missing pulse would show up as a double or absent response.

// File: rtl/virq_trap_pkg.sv
package virq_trap_pkg;
  localparam int CTL_W = 16;

  // positions of the controls inside the hypervisor control word
  localparam int POS_TRAP_COMMON = 10;
  localparam int POS_TRAP_GRP0   = 11;
  localparam int POS_TRAP_GRP1   = 12;
  localparam int POS_TRAP_SEI    = 13;
  localparam int POS_TRAP_DEACT  = 14;
  localparam int POS_DIRECT_MASK = 15;

  localparam logic [1:0] LVL_GUEST = 2'd1;

  typedef enum logic [1:0] {
    CLS_GRP0   = 2'd0,
    CLS_GRP1   = 2'd1,
    CLS_COMMON = 2'd2,
    CLS_DEACT  = 2'd3
  } acc_class_e;
endpackage

// File: rtl/vtrap_rst_sync.sv
module vtrap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/vtrap_ctl_mask.sv
module vtrap_ctl_mask
  import virq_trap_pkg::*;
#(
  parameter bit HAS_SEI         = 1'b1,
  parameter bit HAS_DEACT_TRAP  = 1'b1,
  parameter bit HAS_DIRECT_MASK = 1'b1
) (
  input  logic [CTL_W-1:0] ctl_i,
  output logic [CTL_W-1:0] ctl_eff_o
);
  function automatic logic [CTL_W-1:0] support_mask();
    logic [CTL_W-1:0] m;
    m = '1;
    m[POS_TRAP_SEI]    = HAS_SEI;
    m[POS_TRAP_DEACT]  = HAS_DEACT_TRAP;
    m[POS_DIRECT_MASK] = HAS_DIRECT_MASK;
    return m;
  endfunction

  localparam logic [CTL_W-1:0] KEEP = support_mask();

  for (genvar g = 0; g < CTL_W; g++) begin : g_bit
    if (KEEP[g]) begin : g_keep
      assign ctl_eff_o[g] = ctl_i[g];
    end else begin : g_tie
      assign ctl_eff_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/vtrap_eval.sv
module vtrap_eval
  import virq_trap_pkg::*;
#(
  parameter bit PHYS_DEACT_TRAP = 1'b0
) (
  input  logic       vld,
  input  logic [1:0] cls,
  input  logic       wr,
  input  logic       virt,
  input  logic [1:0] lvl,
  input  logic       en_common,
  input  logic       en_grp0,
  input  logic       en_grp1,
  input  logic       en_deact,
  output logic       trap_hit,
  output logic       pass_hit
);
  acc_class_e cls_e;
  logic       guest;
  logic       deact_wr_sel;
  logic       sel;

  always_comb begin
    cls_e        = acc_class_e'(cls);
    guest        = vld && (lvl == LVL_GUEST);
    deact_wr_sel = wr && en_deact && (virt || PHYS_DEACT_TRAP);
    case (cls_e)
      CLS_GRP0:   sel = en_grp0;
      CLS_GRP1:   sel = en_grp1;
      CLS_COMMON: sel = en_common;
      CLS_DEACT:  sel = en_common || deact_wr_sel;
      default:    sel = 1'b0;
    endcase
    trap_hit = guest && sel;
    pass_hit = vld && !trap_hit;
  end
endmodule

// File: rtl/vtrap_pipe.sv
module vtrap_pipe (
  input  logic clk,
  input  logic srst_n,
  input  logic trap_hit,
  input  logic pass_hit,
  input  logic sei_hit,
  output logic trap_q,
  output logic pass_q,
  output logic sei_q
);
  logic upd;
  logic trap_d, pass_d, sei_d;

  always_comb begin
    trap_d = trap_hit;
    pass_d = pass_hit;
    sei_d  = sei_hit;
    // load only when something is raised or must be dropped
    upd    = trap_hit | pass_hit | sei_hit | trap_q | pass_q | sei_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      trap_q <= 1'b0;
      pass_q <= 1'b0;
      sei_q  <= 1'b0;
    end else if (upd) begin
      trap_q <= trap_d;
      pass_q <= pass_d;
      sei_q  <= sei_d;
    end
  end
endmodule

// File: rtl/virq_trap_decoder.sv
module virq_trap_decoder
  import virq_trap_pkg::*;
#(
  parameter bit HAS_SEI         = 1'b1,
  parameter bit HAS_DEACT_TRAP  = 1'b1,
  parameter bit PHYS_DEACT_TRAP = 1'b0,
  parameter bit HAS_DIRECT_MASK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld_i,
  input  logic [1:0]       acc_class_i,
  input  logic             acc_write_i,
  input  logic             acc_virt_i,
  input  logic [1:0]       acc_lvl_i,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             sei_evt_i,
  output logic             trap_o,
  output logic             pass_o,
  output logic             sei_trap_o,
  output logic             dimask_o,
  output logic [CTL_W-1:0] ctl_eff_o
);
  logic srst_n;
  logic trap_hit, pass_hit, sei_hit;

  vtrap_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  vtrap_ctl_mask #(
    .HAS_SEI         (HAS_SEI),
    .HAS_DEACT_TRAP  (HAS_DEACT_TRAP),
    .HAS_DIRECT_MASK (HAS_DIRECT_MASK)
  ) u_mask (
    .ctl_i     (ctl_i),
    .ctl_eff_o (ctl_eff_o)
  );

  vtrap_eval #(.PHYS_DEACT_TRAP(PHYS_DEACT_TRAP)) u_eval (
    .vld       (acc_vld_i),
    .cls       (acc_class_i),
    .wr        (acc_write_i),
    .virt      (acc_virt_i),
    .lvl       (acc_lvl_i),
    .en_common (ctl_eff_o[POS_TRAP_COMMON]),
    .en_grp0   (ctl_eff_o[POS_TRAP_GRP0]),
    .en_grp1   (ctl_eff_o[POS_TRAP_GRP1]),
    .en_deact  (ctl_eff_o[POS_TRAP_DEACT]),
    .trap_hit  (trap_hit),
    .pass_hit  (pass_hit)
  );

  assign sei_hit  = sei_evt_i & ctl_eff_o[POS_TRAP_SEI];
  assign dimask_o = ctl_eff_o[POS_DIRECT_MASK];

  vtrap_pipe u_pipe (
    .clk      (clk),
    .srst_n   (srst_n),
    .trap_hit (trap_hit),
    .pass_hit (pass_hit),
    .sei_hit  (sei_hit),
    .trap_q   (trap_o),
    .pass_q   (pass_o),
    .sei_q    (sei_trap_o)
  );
endmodule

// File: rtl/vtrap_chk.sv
module vtrap_chk #(
  parameter bit HAS_SEI         = 1'b1,
  parameter bit HAS_DIRECT_MASK = 1'b1
) (
  input logic        clk,
  input logic        srst_n,
  input logic        acc_vld_i,
  input logic [1:0]  acc_class_i,
  input logic [1:0]  acc_lvl_i,
  input logic [15:0] ctl_i,
  input logic        sei_evt_i,
  input logic        trap_o,
  input logic        pass_o,
  input logic        sei_trap_o,
  input logic        dimask_o
);
  logic armed;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R7
  one_resp_chk: assert property (@(posedge clk) disable iff (!armed)
    !(trap_o && pass_o));

  // R7
  resp_follows_chk: assert property (@(posedge clk) disable iff (!armed)
    acc_vld_i |=> (trap_o || pass_o));

  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!armed)
    !acc_vld_i |=> !(trap_o || pass_o));

  // R6
  hyp_pass_chk: assert property (@(posedge clk) disable iff (!armed)
    (acc_vld_i && acc_lvl_i != 2'd1) |=> (pass_o && !trap_o));

  // R2
  grp1_trap_chk: assert property (@(posedge clk) disable iff (!armed)
    (acc_vld_i && acc_lvl_i == 2'd1 && acc_class_i == 2'd1 && ctl_i[12]) |=> trap_o);

  // R3
  grp0_trap_chk: assert property (@(posedge clk) disable iff (!armed)
    (acc_vld_i && acc_lvl_i == 2'd1 && acc_class_i == 2'd0 && ctl_i[11]) |=> trap_o);

  // R4
  common_trap_chk: assert property (@(posedge clk) disable iff (!armed)
    (acc_vld_i && acc_lvl_i == 2'd1 && acc_class_i[1] && ctl_i[10]) |=> trap_o);

  // R8
  sei_trap_chk: assert property (@(posedge clk) disable iff (!armed)
    (sei_evt_i && ctl_i[13] && HAS_SEI) |=> sei_trap_o);

  // R8
  sei_cause_chk: assert property (@(posedge clk) disable iff (!armed)
    sei_trap_o |-> $past(sei_evt_i));

  // R9
  dimask_src_chk: assert property (@(posedge clk) disable iff (!armed)
    dimask_o |-> (ctl_i[15] && HAS_DIRECT_MASK));
endmodule

bind virq_trap_decoder vtrap_chk #(
  .HAS_SEI         (HAS_SEI),
  .HAS_DIRECT_MASK (HAS_DIRECT_MASK)
) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .acc_vld_i   (acc_vld_i),
  .acc_class_i (acc_class_i),
  .acc_lvl_i   (acc_lvl_i),
  .ctl_i       (ctl_i),
  .sei_evt_i   (sei_evt_i),
  .trap_o      (trap_o),
  .pass_o      (pass_o),
  .sei_trap_o  (sei_trap_o),
  .dimask_o    (dimask_o)
);

// File: tb/sim_virq_trap_decoder.sv
module sim_virq_trap_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        vld;
  logic [1:0]  cls;
  logic        wr;
  logic        vt;
  logic [1:0]  lvl;
  logic [15:0] ctl;
  logic        sei;

  logic        trap_w [3];
  logic        pass_w [3];
  logic        seit_w [3];
  logic        dm_w   [3];
  logic [15:0] eff_w  [3];

  // configurations: u0, u1, u2
  localparam bit P_SEI [3] = '{1'b1, 1'b0, 1'b1};
  localparam bit P_DIR [3] = '{1'b1, 1'b1, 1'b0};
  localparam bit P_PHY [3] = '{1'b0, 1'b1, 1'b1};
  localparam bit P_DM  [3] = '{1'b1, 1'b0, 1'b1};

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  virq_trap_decoder #(.HAS_SEI(P_SEI[0]), .HAS_DEACT_TRAP(P_DIR[0]),
    .PHYS_DEACT_TRAP(P_PHY[0]), .HAS_DIRECT_MASK(P_DM[0])) u0 (
    .clk(clk), .rst_n(rst_n), .acc_vld_i(vld), .acc_class_i(cls),
    .acc_write_i(wr), .acc_virt_i(vt), .acc_lvl_i(lvl), .ctl_i(ctl),
    .sei_evt_i(sei), .trap_o(trap_w[0]), .pass_o(pass_w[0]),
    .sei_trap_o(seit_w[0]), .dimask_o(dm_w[0]), .ctl_eff_o(eff_w[0]));

  virq_trap_decoder #(.HAS_SEI(P_SEI[1]), .HAS_DEACT_TRAP(P_DIR[1]),
    .PHYS_DEACT_TRAP(P_PHY[1]), .HAS_DIRECT_MASK(P_DM[1])) u1 (
    .clk(clk), .rst_n(rst_n), .acc_vld_i(vld), .acc_class_i(cls),
    .acc_write_i(wr), .acc_virt_i(vt), .acc_lvl_i(lvl), .ctl_i(ctl),
    .sei_evt_i(sei), .trap_o(trap_w[1]), .pass_o(pass_w[1]),
    .sei_trap_o(seit_w[1]), .dimask_o(dm_w[1]), .ctl_eff_o(eff_w[1]));

  virq_trap_decoder #(.HAS_SEI(P_SEI[2]), .HAS_DEACT_TRAP(P_DIR[2]),
    .PHYS_DEACT_TRAP(P_PHY[2]), .HAS_DIRECT_MASK(P_DM[2])) u2 (
    .clk(clk), .rst_n(rst_n), .acc_vld_i(vld), .acc_class_i(cls),
    .acc_write_i(wr), .acc_virt_i(vt), .acc_lvl_i(lvl), .ctl_i(ctl),
    .sei_evt_i(sei), .trap_o(trap_w[2]), .pass_o(pass_w[2]),
    .sei_trap_o(seit_w[2]), .dimask_o(dm_w[2]), .ctl_eff_o(eff_w[2]));

  function automatic bit exp_trap(bit v, logic [1:0] c, bit w, bit virt,
                                  logic [1:0] l, logic [15:0] k, int i);
    if (!v || l != 2'd1) return 1'b0;
    case (c)
      2'd0: return k[11];
      2'd1: return k[12];
      2'd2: return k[10];
      default: return k[10] | (w & k[14] & P_DIR[i] & (virt | P_PHY[i]));
    endcase
  endfunction

  function automatic string trap_tag(bit v, logic [1:0] c, logic [1:0] l);
    if (!v) return "R7";
    if (l != 2'd1) return "R6";
    case (c)
      2'd0: return "R3";
      2'd1: return "R2";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic cmp(string tag, int i, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s u%0d %s: actual %h expected %h", tag, i, what, act, exp);
    end
  endtask

  // check all instances; in_rst forces the reset expectations (R1)
  task automatic check_all(bit v, bit s, bit in_rst);
    for (int i = 0; i < 3; i++) begin
      bit et;
      bit ep;
      logic [15:0] ee;
      et = in_rst ? 1'b0 : exp_trap(v, cls, wr, vt, lvl, ctl, i);
      ep = in_rst ? 1'b0 : (v & ~et);
      ee = ctl;
      if (!P_SEI[i]) ee[13] = 1'b0;
      if (!P_DIR[i]) ee[14] = 1'b0;
      if (!P_DM[i])  ee[15] = 1'b0;
      cmp(in_rst ? "R1" : trap_tag(v, cls, lvl), i, "trap", 16'(trap_w[i]), 16'(et));
      cmp(in_rst ? "R1" : "R7", i, "pass", 16'(pass_w[i]), 16'(ep));
      cmp(in_rst ? "R1" : "R8", i, "sei_trap", 16'(seit_w[i]),
          16'(in_rst ? 1'b0 : (s & ctl[13] & P_SEI[i])));
      cmp("R9", i, "dimask", 16'(dm_w[i]), 16'(ctl[15] & P_DM[i]));
      cmp("R10", i, "ctl_eff", eff_w[i], ee);
    end
  endtask

  // drive at negedge, check one clock later at the next negedge
  task automatic step(bit v, logic [1:0] c, bit w, bit virt, logic [1:0] l,
                      logic [15:0] k, bit s);
    vld = v; cls = c; wr = w; vt = virt; lvl = l; ctl = k; sei = s;
    @(posedge clk);
    @(negedge clk);
    check_all(v, s, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    vld = 1'b0; cls = '0; wr = 1'b0; vt = 1'b0; lvl = '0; sei = 1'b0;
    ctl = 16'hFFFF;
    // R1: held in reset with every enable set and strobes offered
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      vld = 1'b1; sei = 1'b1; lvl = 2'd1;
      @(negedge clk);
      check_all(1'b0, 1'b0, 1'b1);
    end
    vld = 1'b0; sei = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_all(1'b0, 1'b0, 1'b1);
    end

    // R2..R10: all six control bits against every access shape
    for (int c = 0; c < 64; c++) begin
      for (int v = 0; v < 64; v++) begin
        logic [15:0] k;
        logic [5:0]  vb;
        vb = 6'(v);
        k  = {6'(c), 10'((c * 37 + v * 11) & 10'h3FF)};
        if (v % 5 == 0)
          step(1'b0, vb[1:0], vb[2], vb[3], vb[5:4], k, vb[0] ^ vb[3]);
        step(1'b1, vb[1:0], vb[2], vb[3], vb[5:4], k, vb[0] ^ vb[3]);
      end
    end
    step(1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 16'hFFFF, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule